// File: doc/BRIEF.md
# Flooring Integer Divider

This block divides a 64-bit dividend by a 64-bit divisor and returns both a quotient and a remainder. A mode input selects unsigned or two's complement signed arithmetic. In signed mode the quotient is rounded down, toward negative infinity. Any nonzero remainder therefore carries the sign of the divisor, rather than the sign of the dividend as it would with truncating division.

A caller pulses `start_i` for one cycle with the operands and the mode on the inputs. The result appears a fixed number of cycles later, whatever the operand values, so a sequencer can schedule around it without a handshake. The divide is iterative and retires several quotient bits per clock. It then applies the sign and floor correction and holds the result until the fixed completion cycle.

A zero divisor does not produce a numeric result. It raises an error flag together with the completion strobe, and both result words read zero. Only one divide runs at a time, and a start pulse that arrives while a divide is in flight is ignored.

Top module: `floor_divider`

## Requirements
- R1: `done_o` goes high on the 10th rising clock edge after the edge that accepted `start_i`, for every operand pair and both modes.
- R2: With `signed_i` = 0 the operands are unsigned. The quotient is the floor of dividend/divisor, and the remainder equals dividend − quotient·divisor, which is below the divisor.
- R3: With `signed_i` = 1 the operands are two's complement. The quotient is the largest integer not above the true ratio, so it rounds toward negative infinity.
- R4: In signed mode a nonzero remainder has the same sign as the divisor, its magnitude is below the divisor's magnitude, and quotient·divisor + remainder equals the dividend.
- R5: A divisor of zero in either mode drives `div_zero_o` high in the same cycle as `done_o`, with quotient and remainder both zero.
- R6: In signed mode the most negative dividend divided by −1 gives the most negative value as quotient and 0 as remainder.
- R7: A `start_i` pulse that arrives while a divide is in progress is ignored. The running divide keeps its operands, and no extra completion follows.
- R8: After reset `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all 0.
- R9: `done_o` is high for exactly one cycle. The quotient, remainder and error flag hold their values until the next completion.
- R10: A new divide may be started in the cycle in which `done_o` is high.
- R11: `div_zero_o` is low at completion whenever the divisor was nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a divide |
| signed_i | input | 1 | 1 = signed flooring divide, 0 = unsigned divide |
| dividend_i | input | 64 | Dividend, sampled with `start_i` |
| divisor_i | input | 64 | Divisor, sampled with `start_i` |
| quotient_o | output | 64 | Quotient of the last completed divide |
| remainder_o | output | 64 | Remainder of the last completed divide |
| done_o | output | 1 | One-cycle completion strobe |
| div_zero_o | output | 1 | Divisor was zero; valid with and held after `done_o` |

## Verification
The checker assumes that `start_i` is driven to a known value on every clock after reset, and that operand and mode values are sampled only in the cycle in which a start is accepted. It therefore records its own copy of the operands at that point. The bench changes inputs only on falling edges and keeps every start pulse to a single cycle. The one exception is the deliberately overlapping pulse in the busy scenario, whose operands differ so that accepting it would be visible. The bench drives the boundary values directly: the most negative dividend, an all-ones divisor, a zero divisor, and exact divides with negative operands.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic {
    FD_IDLE = 1'b0,
    FD_RUN  = 1'b1
  } fd_state_t;

endpackage

// File: rtl/fdiv_operand_prep.sv
// Splits operands into sign flags and magnitudes; unsigned mode passes values through.
module fdiv_operand_prep #(
  parameter int W = 64
) (
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_a_o,
  output logic         neg_b_o,
  output logic         zero_b_o
);

  always_comb begin
    neg_a_o  = signed_i & dividend_i[W-1];
    neg_b_o  = signed_i & divisor_i[W-1];
    // The magnitude of the most negative value is itself when read as unsigned.
    mag_a_o  = neg_a_o ? (~dividend_i + 1'b1) : dividend_i;
    mag_b_o  = neg_b_o ? (~divisor_i + 1'b1) : divisor_i;
    zero_b_o = (divisor_i == '0);
  end

endmodule

// File: rtl/fdiv_radix_step.sv
// One clock's worth of restoring division: K quotient bits per call.
module fdiv_radix_step #(
  parameter int W = 64,
  parameter int K = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);

  logic [W-1:0] rem_c [K+1];
  logic [W-1:0] quo_c [K+1];

  assign rem_c[0] = rem_i;
  assign quo_c[0] = quo_i;

  for (genvar g = 0; g < K; g++) begin : g_bit
    logic [W:0] shifted;
    logic [W:0] trial;
    always_comb begin
      shifted = {rem_c[g], quo_c[g][W-1]};
      trial   = shifted - {1'b0, dvs_i};
      if (!trial[W]) begin
        rem_c[g+1] = trial[W-1:0];
        quo_c[g+1] = {quo_c[g][W-2:0], 1'b1};
      end else begin
        rem_c[g+1] = shifted[W-1:0];
        quo_c[g+1] = {quo_c[g][W-2:0], 1'b0};
      end
    end
  end

  assign rem_o = rem_c[K];
  assign quo_o = quo_c[K];

endmodule

// File: rtl/fdiv_sign_fix.sv
// Restores signs on the magnitude result and moves truncation to floor rounding.
module fdiv_sign_fix #(
  parameter int W = 64
) (
  input  logic [W-1:0] mag_q_i,
  input  logic [W-1:0] mag_r_i,
  input  logic         neg_a_i,
  input  logic         neg_b_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] trunc_q;
  logic [W-1:0] trunc_r;
  logic         adjust;

  always_comb begin
    trunc_q = (neg_a_i ^ neg_b_i) ? ('0 - mag_q_i) : mag_q_i;
    trunc_r = neg_a_i ? ('0 - mag_r_i) : mag_r_i;
    // The truncated remainder follows the dividend's sign; a mismatch with the divisor needs one step down.
    adjust  = (mag_r_i != '0) && (neg_a_i != neg_b_i);
    quo_o   = adjust ? (trunc_q - 1'b1) : trunc_q;
    rem_o   = adjust ? (trunc_r + divisor_i) : trunc_r;
  end

endmodule

// File: rtl/floor_divider.sv
module floor_divider #(
  parameter int W   = 64,
  parameter int LAT = 10,
  parameter int K   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         done_o,
  output logic         div_zero_o
);
  import fdiv_pkg::*;

  // K must divide W, and W/K must not exceed LAT-1.
  localparam int STEPS = W / K;
  localparam int CW    = $clog2(LAT + 1);

  fd_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q, braw_q;
  logic          nega_q, negb_q, zero_q;

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_a, neg_b, zero_b;
  logic [W-1:0]  step_rem, step_quo;
  logic [W-1:0]  fix_q, fix_r;

  fdiv_operand_prep #(.W(W)) u_prep (
    .signed_i  (signed_i),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .mag_a_o   (mag_a),
    .mag_b_o   (mag_b),
    .neg_a_o   (neg_a),
    .neg_b_o   (neg_b),
    .zero_b_o  (zero_b)
  );

  fdiv_radix_step #(.W(W), .K(K)) u_step (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .dvs_i(dvs_q),
    .rem_o(step_rem),
    .quo_o(step_quo)
  );

  fdiv_sign_fix #(.W(W)) u_fix (
    .mag_q_i  (quo_q),
    .mag_r_i  (rem_q),
    .neg_a_i  (nega_q),
    .neg_b_i  (negb_q),
    .divisor_i(braw_q),
    .quo_o    (fix_q),
    .rem_o    (fix_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= FD_IDLE;
      cnt_q       <= '0;
      rem_q       <= '0;
      quo_q       <= '0;
      dvs_q       <= '0;
      braw_q      <= '0;
      nega_q      <= 1'b0;
      negb_q      <= 1'b0;
      zero_q      <= 1'b0;
      quotient_o  <= '0;
      remainder_o <= '0;
      done_o      <= 1'b0;
      div_zero_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        FD_IDLE: begin
          if (start_i) begin
            state_q <= FD_RUN;
            cnt_q   <= CW'(1);
            rem_q   <= '0;
            quo_q   <= mag_a;
            dvs_q   <= mag_b;
            braw_q  <= divisor_i;
            nega_q  <= neg_a;
            negb_q  <= neg_b;
            zero_q  <= zero_b;
          end
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q <= CW'(STEPS)) begin
            rem_q <= step_rem;
            quo_q <= step_quo;
          end
          if (cnt_q == CW'(LAT)) begin
            state_q     <= FD_IDLE;
            done_o      <= 1'b1;
            div_zero_o  <= zero_q;
            quotient_o  <= zero_q ? '0 : fix_q;
            remainder_o <= zero_q ? '0 : fix_r;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/floor_divider_chk.sv
module floor_divider_chk #(
  parameter int W   = 64,
  parameter int LAT = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic         done_o,
  input logic         div_zero_o
);

  localparam int CW = $clog2(LAT + 3);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic          c_busy;
  logic [CW-1:0] c_cnt;
  logic [W-1:0]  c_a, c_b;
  logic          c_s;
  logic          take;

  assign take = start_i && (!c_busy || done_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_busy <= 1'b0;
      c_cnt  <= '0;
      c_a    <= '0;
      c_b    <= '0;
      c_s    <= 1'b0;
    end else if (take) begin
      c_busy <= 1'b1;
      c_cnt  <= CW'(1);
      c_a    <= dividend_i;
      c_b    <= divisor_i;
      c_s    <= signed_i;
    end else begin
      if (c_busy && done_o) c_busy <= 1'b0;
      if (c_busy && c_cnt != '1) c_cnt <= c_cnt + 1'b1;
    end
  end

  logic [W-1:0] recon, mag_r, mag_b;
  logic         res_ok;
  always_comb begin
    recon  = quotient_o * c_b + remainder_o;
    mag_r  = remainder_o[W-1] ? ('0 - remainder_o) : remainder_o;
    mag_b  = c_b[W-1] ? ('0 - c_b) : c_b;
    if (c_s)
      res_ok = (recon == c_a) && ((remainder_o == '0) ||
               ((remainder_o[W-1] == c_b[W-1]) && (mag_r < mag_b)));
    else
      res_ok = (recon == c_a) && (remainder_o < c_b);
  end

  // R1
  done_when_due_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (c_busy && c_cnt == CW'(LAT + 1)));
  // R1
  due_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
    (c_busy && c_cnt == CW'(LAT + 1)) |-> done_o);
  // R2
  // R3
  // R4
  result_math_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !div_zero_o) |-> res_ok);
  // R5
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && div_zero_o) |-> (quotient_o == '0 && remainder_o == '0));
  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (div_zero_o == (c_b == '0)));
  // R6
  min_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && c_s && c_a == MINV && c_b == '1) |-> (quotient_o == MINV && remainder_o == '0));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));

endmodule

bind floor_divider floor_divider_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
  .dividend_i(dividend_i), .divisor_i(divisor_i),
  .quotient_o(quotient_o), .remainder_o(remainder_o),
  .done_o(done_o), .div_zero_o(div_zero_o)
);

// File: tb/floor_divider_test.sv
`timescale 1ns/1ps
module floor_divider_test;

  localparam int W = 64;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic [W-1:0] quotient_o, remainder_o;
  logic         done_o, div_zero_o;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  floor_divider uut (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .done_o(done_o), .div_zero_o(div_zero_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected values built from the requirement text.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                       output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb, tq, tr;
    if (b == '0) begin
      q = '0; r = '0;
    end else if (!s) begin
      q = a / b; r = a % b;
    end else if (a == MINV && b == '1) begin
      q = MINV; r = '0;
    end else begin
      sa = longint'(a); sb = longint'(b);
      tq = sa / sb; tr = sa % sb;
      if (tr != 0 && ((tr < 0) != (sb < 0))) begin
        tq = tq - 1; tr = tr + sb;
      end
      q = tq; r = tr;
    end
  endtask

  // Called at a falling edge; returns at the falling edge after completion.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit s, input string req);
    logic [W-1:0] eq, er;
    model(a, b, s, eq, er);
    start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 1'b0;
    repeat (9) @(negedge clk);
    check({req, " R1 early"}, W'(done_o), W'(0));
    @(negedge clk);
    check({req, " R1 done"}, W'(done_o), W'(1));
    check({req, " quotient"}, quotient_o, eq);
    check({req, " remainder"}, remainder_o, er);
    check({req, " R11/R5 flag"}, W'(div_zero_o), W'(b == '0));
  endtask

  task automatic t_reset();
    check("R8 done", W'(done_o), W'(0));
    check("R8 flag", W'(div_zero_o), W'(0));
    check("R8 quotient", quotient_o, '0);
    check("R8 remainder", remainder_o, '0);
  endtask

  task automatic t_unsigned();
    run_div(64'd100, 64'd7, 1'b0, "R2 small");
    run_div(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R2 max/1");
    run_div(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R2 near");
    run_div(64'd5, 64'd9, 1'b0, "R2 below");
    run_div(64'hDEAD_BEEF_0123_4567, 64'h0000_0001_0000_0003, 1'b0, "R2 wide");
  endtask

  task automatic t_signed();
    run_div(64'd7, 64'd2, 1'b1, "R3 pos/pos");
    run_div(-64'sd7, 64'd2, 1'b1, "R3 neg/pos");
    run_div(64'd7, -64'sd2, 1'b1, "R4 pos/neg");
    run_div(-64'sd7, -64'sd2, 1'b1, "R4 neg/neg");
    run_div(-64'sd12, 64'd3, 1'b1, "R3 exact");
    run_div(64'd12, -64'sd3, 1'b1, "R4 exact");
    run_div(-64'sd1, 64'd1000, 1'b1, "R4 small neg");
    run_div(MINV, 64'd1, 1'b1, "R3 min/1");
    run_div(MINV, 64'd3, 1'b1, "R4 min/3");
  endtask

  task automatic t_wrap();
    run_div(MINV, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 wrap");
  endtask

  task automatic t_zero();
    run_div(64'd42, 64'd0, 1'b0, "R5 unsigned");
    run_div(-64'sd42, 64'd0, 1'b1, "R5 signed");
  endtask

  task automatic t_busy();
    logic [W-1:0] eq, er;
    int extra;
    model(64'd1000, 64'd10, 1'b0, eq, er);
    start_i = 1'b1; signed_i = 1'b0; dividend_i = 64'd1000; divisor_i = 64'd10;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1; dividend_i = 64'd77; divisor_i = 64'd0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 early", W'(done_o), W'(0));
    @(negedge clk);
    check("R7 done", W'(done_o), W'(1));
    check("R7 quotient", quotient_o, eq);
    check("R7 flag", W'(div_zero_o), W'(0));
    extra = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check("R7 no second done", W'(extra), W'(0));
  endtask

  task automatic t_hold();
    logic [W-1:0] q0, r0;
    run_div(-64'sd9, 64'd4, 1'b1, "R9 setup");
    q0 = quotient_o; r0 = remainder_o;
    @(negedge clk);
    check("R9 pulse", W'(done_o), W'(0));
    repeat (4) @(negedge clk);
    check("R9 hold q", quotient_o, q0);
    check("R9 hold r", remainder_o, r0);
  endtask

  task automatic t_back2back();
    run_div(64'd81, 64'd9, 1'b0, "R10 first");
    run_div(64'd50, -64'sd8, 1'b1, "R10 second");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_unsigned();
    @(negedge clk);
    t_signed();
    t_wrap();
    t_zero();
    @(negedge clk);
    t_busy();
    t_hold();
    @(negedge clk);
    t_back2back();
    repeat (2) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #4_000_000;
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule